// File: doc/BRIEF.md
# Hysteretic Thermostat Comparator with Latched Excursion Flags

This block sits behind a temperature converter. Each time a new 9-bit reading is marked valid, the block compares it against a programmable upper trip point and a programmable lower release point. From that comparison it keeps an internal heating-alarm state with hysteresis. The alarm becomes active when a reading reaches the upper trip point. It stays active until a reading falls strictly below the release point.

The alarm drives a single output pin. A polarity input selects whether the active level on that pin is high or low. Two status flags record whether any reading has ever touched or crossed either limit. These flags are sticky: once hardware sets a flag, it stays set until software writes a zero to it.

Thresholds, polarity and flag writes come from registers held elsewhere. This block only evaluates them.

Top module: `tstat_hyst_core`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, the internal alarm state is inactive and both flags read 0.
- R2: On a valid reading where reading >= upper trip point, the alarm is active from the next cycle.
- R3: On a valid reading that is strictly below the release point, and not at or above the upper trip point, the alarm is inactive from the next cycle. A reading equal to the release point leaves the alarm unchanged.
- R4: Without a valid pulse, the alarm state and both flags keep their values, whatever the reading input does.
- R5: The pin equals the alarm state when the polarity input is 1, and its inverse when the polarity input is 0. A change of polarity shows on the pin in the same cycle.
- R6: The high flag (flag bit 0) becomes 1 on any valid reading >= upper trip point.
- R7: The low flag (flag bit 1) becomes 1 on any valid reading <= release point.
- R8: A flag write strobe clears the selected flag when its write-data bit is 0. Writing a 1 has no effect on the flag.
- R9: If a flag is set by a reading and cleared by a write in the same cycle, the flag ends up set.
- R10: Readings and limits are 9-bit two's complement with 0.5 °C per LSB, and all comparisons are signed. For example, +5 °C = 0x00A is above -10 °C = 0x1EC.
- R11: If a reading meets the set condition and the clear condition at the same time (upper trip point at or below the release point), the alarm becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_i | input | 9 | Latest reading, signed, 0.5 °C LSB |
| temp_valid_i | input | 1 | One-cycle pulse: temp_i is a new completed reading |
| trip_hi_i | input | 9 | Upper trip point, signed |
| trip_lo_i | input | 9 | Release point, signed |
| pol_i | input | 1 | 1 = pin active high, 0 = pin active low |
| flag_wr_i | input | 2 | Flag write strobes; bit 0 high flag, bit 1 low flag |
| flag_wdata_i | input | 2 | Flag write data; 0 clears, 1 ignored |
| tstat_o | output | 1 | Thermostat pin level |
| hi_flag_o | output | 1 | Sticky high-excursion flag |
| lo_flag_o | output | 1 | Sticky low-excursion flag |

## Verification
The hardest cases to reach are the collisions. In one, a hardware set and a software clear land on the same flag in one cycle. In the other, the limits are programmed so that a reading satisfies the set and the clear condition together. The directed stimulus reaches the first by raising a flag write strobe, with data 0, in the same cycle as a valid pulse whose reading crosses the limit. It reaches the second by first driving the alarm inactive with a cold reading, then reprogramming the limits to overlap before sending a reading inside the overlap. Negative limits are paired with a positive reading, so an unsigned comparison would give the opposite answer.

// File: rtl/tstat_pkg.sv
package tstat_pkg;
    localparam int TEMP_W = 9;
    localparam int FLAG_N = 2;
    localparam int FLAG_HI = 0;
    localparam int FLAG_LO = 1;

    typedef logic signed [TEMP_W-1:0] temp_t;

    typedef struct packed {
        logic at_or_above_hi;
        logic below_lo;
        logic at_or_below_lo;
    } cmp_res_t;

    function automatic cmp_res_t compare_limits(temp_t t, temp_t hi, temp_t lo);
        cmp_res_t r;
        r.at_or_above_hi = (t >= hi);
        r.below_lo       = (t < lo);
        r.at_or_below_lo = (t <= lo);
        return r;
    endfunction
endpackage

// File: rtl/tstat_cmp.sv
module tstat_cmp
    import tstat_pkg::*;
(
    input  logic [TEMP_W-1:0] temp_i,
    input  logic [TEMP_W-1:0] hi_i,
    input  logic [TEMP_W-1:0] lo_i,
    output cmp_res_t          res_o
);
    always_comb begin
        res_o = compare_limits(temp_t'(temp_i), temp_t'(hi_i), temp_t'(lo_i));
    end
endmodule

// File: rtl/tstat_hyst.sv
module tstat_hyst
    import tstat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     upd_i,
    input  cmp_res_t cmp_i,
    output logic     active_o
);
    logic active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
        end else if (upd_i) begin
            if (cmp_i.at_or_above_hi) begin
                active_q <= 1'b1;
            end else if (cmp_i.below_lo) begin
                active_q <= 1'b0;
            end
        end
    end

    assign active_o = active_q;
endmodule

// File: rtl/tstat_sticky.sv
module tstat_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic wr_i,
    input  logic wdata_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (wr_i && !wdata_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/tstat_hyst_core.sv
module tstat_hyst_core
    import tstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              temp_valid_i,
    input  logic [TEMP_W-1:0] trip_hi_i,
    input  logic [TEMP_W-1:0] trip_lo_i,
    input  logic              pol_i,
    input  logic [FLAG_N-1:0] flag_wr_i,
    input  logic [FLAG_N-1:0] flag_wdata_i,
    output logic              tstat_o,
    output logic              hi_flag_o,
    output logic              lo_flag_o
);
    cmp_res_t          cmp;
    logic              alarm;
    logic [FLAG_N-1:0] flag_set;
    logic [FLAG_N-1:0] flags;

    tstat_cmp u_cmp (
        .temp_i (temp_i),
        .hi_i   (trip_hi_i),
        .lo_i   (trip_lo_i),
        .res_o  (cmp)
    );

    tstat_hyst u_hyst (
        .clk      (clk),
        .rst      (rst),
        .upd_i    (temp_valid_i),
        .cmp_i    (cmp),
        .active_o (alarm)
    );

    always_comb begin
        flag_set          = '0;
        flag_set[FLAG_HI] = temp_valid_i && cmp.at_or_above_hi;
        flag_set[FLAG_LO] = temp_valid_i && cmp.at_or_below_lo;
    end

    for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
        tstat_sticky u_flag (
            .clk     (clk),
            .rst     (rst),
            .set_i   (flag_set[g]),
            .wr_i    (flag_wr_i[g]),
            .wdata_i (flag_wdata_i[g]),
            .flag_o  (flags[g])
        );
    end

    assign tstat_o   = pol_i ? alarm : ~alarm;
    assign hi_flag_o = flags[FLAG_HI];
    assign lo_flag_o = flags[FLAG_LO];
endmodule

// File: rtl/tstat_hyst_core_chk.sv
module tstat_hyst_core_chk
    import tstat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [TEMP_W-1:0] temp_i,
    input logic              temp_valid_i,
    input logic [TEMP_W-1:0] trip_hi_i,
    input logic [TEMP_W-1:0] trip_lo_i,
    input logic              pol_i,
    input logic [FLAG_N-1:0] flag_wr_i,
    input logic [FLAG_N-1:0] flag_wdata_i,
    input logic              alarm,
    input logic              tstat_o,
    input logic              hi_flag_o,
    input logic              lo_flag_o
);
    logic hot, cold, touch_lo;
    assign hot      = $signed(temp_i) >= $signed(trip_hi_i);
    assign cold     = $signed(temp_i) <  $signed(trip_lo_i);
    assign touch_lo = $signed(temp_i) <= $signed(trip_lo_i);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!alarm && !hi_flag_o && !lo_flag_o));

    // R2
    set_on_hot_chk: assert property (@(posedge clk) disable iff (rst)
        (temp_valid_i && hot) |=> alarm);

    // R3
    clear_on_cold_chk: assert property (@(posedge clk) disable iff (rst)
        (temp_valid_i && cold && !hot) |=> !alarm);

    // R4
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !temp_valid_i |=> $stable(alarm));

    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!temp_valid_i && flag_wr_i == '0) |=> ($stable(hi_flag_o) && $stable(lo_flag_o)));

    // R5
    pin_level_chk: assert property (@(posedge clk) disable iff (rst)
        tstat_o == (pol_i ? alarm : !alarm));

    // R6
    hi_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (temp_valid_i && hot) |=> hi_flag_o);

    // R7
    lo_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (temp_valid_i && touch_lo) |=> lo_flag_o);

    // R8
    hi_no_self_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!hi_flag_o && !(temp_valid_i && hot)) |=> !hi_flag_o);
endmodule

bind tstat_hyst_core tstat_hyst_core_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .temp_i       (temp_i),
    .temp_valid_i (temp_valid_i),
    .trip_hi_i    (trip_hi_i),
    .trip_lo_i    (trip_lo_i),
    .pol_i        (pol_i),
    .flag_wr_i    (flag_wr_i),
    .flag_wdata_i (flag_wdata_i),
    .alarm        (alarm),
    .tstat_o      (tstat_o),
    .hi_flag_o    (hi_flag_o),
    .lo_flag_o    (lo_flag_o)
);

// File: tb/tb_tstat_hyst_core.sv
module tb_tstat_hyst_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] temp_i = '0;
    logic       temp_valid_i = 1'b0;
    logic [8:0] trip_hi_i = 9'h050;
    logic [8:0] trip_lo_i = 9'h014;
    logic       pol_i = 1'b1;
    logic [1:0] flag_wr_i = '0;
    logic [1:0] flag_wdata_i = '0;
    logic       tstat_o, hi_flag_o, lo_flag_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    tstat_hyst_core dut (
        .clk(clk), .rst(rst), .temp_i(temp_i), .temp_valid_i(temp_valid_i),
        .trip_hi_i(trip_hi_i), .trip_lo_i(trip_lo_i), .pol_i(pol_i),
        .flag_wr_i(flag_wr_i), .flag_wdata_i(flag_wdata_i),
        .tstat_o(tstat_o), .hi_flag_o(hi_flag_o), .lo_flag_o(lo_flag_o)
    );

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // One valid pulse; outputs sampled on the following negedge
    task automatic convert(logic [8:0] t, logic [1:0] wr = '0, logic [1:0] wd = '0);
        @(negedge clk);
        temp_i = t; temp_valid_i = 1'b1; flag_wr_i = wr; flag_wdata_i = wd;
        @(negedge clk);
        temp_valid_i = 1'b0; flag_wr_i = '0; flag_wdata_i = '0;
    endtask

    task automatic write_flags(logic [1:0] wr, logic [1:0] wd);
        @(negedge clk);
        flag_wr_i = wr; flag_wdata_i = wd;
        @(negedge clk);
        flag_wr_i = '0; flag_wdata_i = '0;
    endtask

    task automatic t_reset;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pin inactive pol=1", tstat_o, 1'b0);
        check("R1 hi flag", hi_flag_o, 1'b0);
        check("R1 lo flag", lo_flag_o, 1'b0);
        pol_i = 1'b0; #1;
        check("R5 pin inactive pol=0", tstat_o, 1'b1);
        pol_i = 1'b1; #1;
    endtask

    task automatic t_hysteresis;
        trip_hi_i = 9'h050; trip_lo_i = 9'h014;   // +40 / +10
        convert(9'h032);                           // +25
        check("R2 between limits stays inactive", tstat_o, 1'b0);
        check("R6 no hi flag", hi_flag_o, 1'b0);
        check("R7 no lo flag", lo_flag_o, 1'b0);
        convert(9'h050);                           // exactly +40
        check("R2 set at trip point", tstat_o, 1'b1);
        check("R6 hi flag set", hi_flag_o, 1'b1);
        convert(9'h014);                           // exactly +10
        check("R3 equal to release holds", tstat_o, 1'b1);
        check("R7 lo flag at release", lo_flag_o, 1'b1);
        @(negedge clk); temp_i = 9'h1D8;           // -20 with no valid
        repeat (3) @(negedge clk);
        check("R4 no valid keeps alarm", tstat_o, 1'b1);
        convert(9'h013);                           // +9.5
        check("R3 strictly below clears", tstat_o, 1'b0);
        pol_i = 1'b0; #1;
        check("R5 pol=0 inactive is high", tstat_o, 1'b1);
        convert(9'h060);
        check("R5 pol=0 active is low", tstat_o, 1'b0);
        pol_i = 1'b1; #1;
        check("R5 pol=1 active is high", tstat_o, 1'b1);
    endtask

    task automatic t_flags;
        write_flags(2'b11, 2'b11);
        check("R8 write 1 hi ignored", hi_flag_o, 1'b1);
        check("R8 write 1 lo ignored", lo_flag_o, 1'b1);
        write_flags(2'b01, 2'b00);
        check("R8 hi cleared", hi_flag_o, 1'b0);
        check("R8 lo untouched", lo_flag_o, 1'b1);
        write_flags(2'b10, 2'b00);
        check("R8 lo cleared", lo_flag_o, 1'b0);
        convert(9'h064, 2'b11, 2'b00);             // +50 with clear of both
        check("R9 set beats clear hi", hi_flag_o, 1'b1);
        check("R9 clear lo applies", lo_flag_o, 1'b0);
        write_flags(2'b01, 2'b00);
        check("R8 clear hi again", hi_flag_o, 1'b0);
    endtask

    task automatic t_signed;
        trip_hi_i = 9'h1EC; trip_lo_i = 9'h1CE;   // -10 / -25
        convert(9'h1C4);                           // -30
        check("R10 negative below release clears", tstat_o, 1'b0);
        check("R10 lo flag negative", lo_flag_o, 1'b1);
        check("R10 hi flag not set", hi_flag_o, 1'b0);
        convert(9'h00A);                           // +5
        check("R10 positive above negative trip", tstat_o, 1'b1);
        check("R10 hi flag positive", hi_flag_o, 1'b1);
    endtask

    task automatic t_overlap;
        trip_hi_i = 9'h050; trip_lo_i = 9'h014;
        convert(9'h000);
        check("R11 precondition inactive", tstat_o, 1'b0);
        trip_hi_i = 9'h000; trip_lo_i = 9'h028;   // 0 / +20
        convert(9'h00A);                           // +5 in overlap
        check("R11 set wins overlap", tstat_o, 1'b1);
    endtask

    initial begin
        t_reset();
        t_hysteresis();
        t_flags();
        t_signed();
        t_overlap();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule